// File: doc/BRIEF.md
# Column Hit Drain with Crossing Timestamps

This block empties one pixel column into a small end-of-column buffer. Every pixel of the column owns a hit flag that is set when its front end fires. The flags stay set until the drain logic has read them out. The block has no frame and no strobe. Whenever at least one flag is pending and the buffer has room, a fixed-priority arbiter picks the pending pixel with the lowest row index. In the first clock the block latches that pixel's row number. In the second clock it resets the pixel and pushes a hit word into the column buffer. Each pixel therefore costs two clocks, whatever the occupancy.

The column also has a shared fast-OR busy line. The block samples it half a clock early, on the falling edge, to gain timing margin, and then detects its rising transition on the next rising edge. On that transition the current bunch-crossing count is stored. The stored count is attached to every hit word selected afterwards, until the next rising transition. The column buffer is a first-in first-out store that absorbs bursts of hits. A chip-level merger downstream pops it.

Top module: `col_drain_readout`

## Requirements
- R1: Right after reset all hit flags are clear, the buffer is empty and not full, `rd_valid` is low, and the stored timestamp is zero.
- R2: A high bit `hit_in[i]` in a cycle sets flag `i` at the next rising edge. The flag stays set until that pixel is drained.
- R3: Among pending pixels, the one with the lowest row index is drained first.
- R4: A pixel is selected at one rising edge. Its flag is cleared and its word is written at the following edge. The next selection can happen at the edge after that, so consecutive pixels clear two cycles apart.
- R5: A hit word is `{timestamp, row}`. The row index occupies the low `ROW_W` bits and the timestamp occupies the upper `TS_W` bits.
- R6: `fast_or` is sampled on the falling clock edge. A low-to-high change of that sample loads `bx_ts` into the stored timestamp at the next rising edge. A level that stays high loads nothing further.
- R7: A word carries the stored timestamp as it was during the cycle in which its pixel was selected. If a capture lands on the same edge as the selection, the word keeps the older value.
- R8: While the buffer is full, no pixel is selected and no flag is cleared. Draining resumes once a word is read.
- R9: If a pixel is cleared in the same cycle that a new hit for it arrives, its flag stays set and that pixel is drained again.
- R10: The buffer returns words in write order. A read request on a non-empty buffer gives the word at the next edge, with `rd_valid` high for one cycle. A read request while the buffer is empty is ignored.
- R11: `fifo_full` is high exactly when `FIFO_DEPTH` words are stored. `fifo_empty` is high exactly when none are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch-crossing clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_in | input | N_ROWS | Per-pixel hit pulses that set the flags |
| fast_or | input | 1 | Shared column busy line |
| bx_ts | input | TS_W | Running bunch-crossing count |
| rd_en | input | 1 | Pop request from the merger |
| rd_data | output | TS_W+ROW_W | Popped hit word |
| rd_valid | output | 1 | `rd_data` holds a new word |
| fifo_empty | output | 1 | Column buffer holds no word |
| fifo_full | output | 1 | Column buffer is full |
| hit_flags | output | N_ROWS | Current pending pixel flags |

## Verification
Two coincidences matter most. In the first, the clear of a pixel falls in the same cycle as a fresh hit on that pixel. The bench provokes this by pulsing the hit line exactly one cycle after selection. It then judges the result by the flag staying set and by two identical words coming out. In the second, a fast-OR rising transition lands on the edge that selects a pixel. The bench raises the line just after the hit is latched, and expects the first word to keep the old timestamp while the next hit gets the new one. Pattern sweeps larger than the buffer also force full-buffer stalls to interleave with reads.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
  typedef enum logic {
    ST_PICK  = 1'b0,
    ST_CLEAR = 1'b1
  } drain_st_t;
endpackage

// File: rtl/cdr_bx_stamp.sv
module cdr_bx_stamp #(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fast_or,
  input  logic [TS_W-1:0] bx_ts,
  output logic [TS_W-1:0] ts_q
);
  logic fo_half;
  logic fo_q;
  logic rise;

  // half-cycle early sample of the busy line
  always_ff @(negedge clk) begin
    if (rst) fo_half <= 1'b0;
    else     fo_half <= fast_or;
  end

  assign rise = fo_half & ~fo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fo_q <= 1'b0;
      ts_q <= '0;
    end else begin
      fo_q <= fo_half;
      if (rise) ts_q <= bx_ts;
    end
  end

  AST_TS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(ts_q)); // R6
  AST_TS_LOAD: assert property (@(posedge clk) disable iff (rst)
    rise |=> (ts_q == $past(bx_ts))); // R6
endmodule

// File: rtl/cdr_prio_pick.sv
module cdr_prio_pick #(
  parameter int N    = 16,
  localparam int IW  = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/cdr_col_fifo.sv
module cdr_col_fifo #(
  parameter int W     = 12,
  parameter int DEPTH = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         rd_valid,
  output logic         empty,
  output logic         full
);
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          push, pop;

  assign full  = (cnt == FULL_CNT);
  assign empty = (cnt == '0);
  assign push  = wr_en && !full;
  assign pop   = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
    if (pop)  rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= pop;
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full); // R8
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= FULL_CNT); // R11
  AST_EMPTY_NOREAD: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en) |=> !rd_valid && empty); // R10
endmodule

// File: rtl/col_drain_readout.sv
module col_drain_readout
  import cdr_pkg::*;
#(
  parameter int N_ROWS     = 16,
  parameter int TS_W       = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int ROW_W     = $clog2(N_ROWS),
  localparam int WORD_W    = TS_W + ROW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_ROWS-1:0] hit_in,
  input  logic              fast_or,
  input  logic [TS_W-1:0]   bx_ts,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic [N_ROWS-1:0] hit_flags
);
  drain_st_t         st_q;
  logic [N_ROWS-1:0] flags_q;
  logic [N_ROWS-1:0] clr_vec;
  logic [N_ROWS-1:0] below_sel;
  logic [ROW_W-1:0]  sel_row_q;
  logic [TS_W-1:0]   sel_ts_q;
  logic [TS_W-1:0]   ts_now;
  logic              pick_any;
  logic [ROW_W-1:0]  pick_idx;
  logic              take;
  logic              wr_en;

  cdr_bx_stamp #(.TS_W(TS_W)) u_stamp (
    .clk     (clk),
    .rst     (rst),
    .fast_or (fast_or),
    .bx_ts   (bx_ts),
    .ts_q    (ts_now)
  );

  cdr_prio_pick #(.N(N_ROWS)) u_pick (
    .req (flags_q),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign take  = (st_q == ST_PICK) && pick_any && !fifo_full;
  assign wr_en = (st_q == ST_CLEAR);

  for (genvar g = 0; g < N_ROWS; g++) begin : g_row
    assign clr_vec[g]   = wr_en && (sel_row_q == ROW_W'(g));
    assign below_sel[g] = (ROW_W'(g) < sel_row_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_PICK;
      flags_q   <= '0;
      sel_row_q <= '0;
      sel_ts_q  <= '0;
    end else begin
      // a new hit wins over the clear of the same pixel
      flags_q <= (flags_q & ~clr_vec) | hit_in;
      case (st_q)
        ST_PICK: if (take) begin
          sel_row_q <= pick_idx;
          sel_ts_q  <= ts_now;
          st_q      <= ST_CLEAR;
        end
        default: st_q <= ST_PICK;
      endcase
    end
  end

  assign hit_flags = flags_q;

  cdr_col_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  ({sel_ts_q, sel_row_q}),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .empty    (fifo_empty),
    .full     (fifo_full)
  );

  AST_TWO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CLEAR) |=> (st_q == ST_PICK)); // R4
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CLEAR) |-> (($past(flags_q) & below_sel) == '0)); // R3
  AST_STALL_KEEP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PICK && fifo_full) |=> ((hit_flags & $past(hit_flags)) == $past(hit_flags))); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (hit_in != '0) |=> ((hit_flags & $past(hit_in)) == $past(hit_in))); // R9
  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $countones(clr_vec) <= 1); // R4
endmodule

// File: tb/col_drain_readout_bench.sv
module col_drain_readout_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NR  = 16;
  localparam int TW  = 8;
  localparam int DEP = 4;
  localparam int RW  = 4;
  localparam int WW  = TW + RW;

  logic          clk = 1'b0;
  logic          rst;
  logic [NR-1:0] hit_in;
  logic          fast_or;
  logic [TW-1:0] bx_ts;
  logic          rd_en;
  logic [WW-1:0] rd_data;
  logic          rd_valid, fifo_empty, fifo_full;
  logic [NR-1:0] hit_flags;

  int total = 0;
  int fails = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  col_drain_readout #(.N_ROWS(NR), .TS_W(TW), .FIFO_DEPTH(DEP)) u_col_drain_readout (
    .clk(clk), .rst(rst), .hit_in(hit_in), .fast_or(fast_or), .bx_ts(bx_ts),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .hit_flags(hit_flags)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic inject(input logic [NR-1:0] m);
    hit_in = m;
    tick();
    hit_in = '0;
  endtask

  task automatic set_ts(input logic [TW-1:0] v);
    bx_ts   = v;
    fast_or = 1'b1;
    tick();
    tick();
    fast_or = 1'b0;
    tick();
  endtask

  task automatic pop(output logic [WW-1:0] w);
    int n = 0;
    while (fifo_empty && n < 200) begin
      tick();
      n++;
    end
    rd_en = 1'b1;
    tick();
    rd_en = 1'b0;
    chk("R10 rd_valid", {31'd0, rd_valid}, 32'd1);
    w = rd_data;
  endtask

  function automatic logic [31:0] word(input int ts, input int r);
    return (ts << RW) | r;
  endfunction

  initial begin
    logic [WW-1:0] w;
    rst = 1'b1; hit_in = '0; fast_or = 1'b0; bx_ts = '0; rd_en = 1'b0;
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 flags", {16'd0, hit_flags}, 32'd0);
    chk("R1 empty", {31'd0, fifo_empty}, 32'd1);
    chk("R1 full",  {31'd0, fifo_full}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    // R10 read of empty buffer ignored
    rd_en = 1'b1; tick(); rd_en = 1'b0;
    chk("R10 empty read valid", {31'd0, rd_valid}, 32'd0);
    chk("R10 empty read empty", {31'd0, fifo_empty}, 32'd1);
    // R1 timestamp zero, R2 flag set
    inject(16'h0020);
    chk("R2 flag set", {16'd0, hit_flags}, 32'h20);
    pop(w);
    chk("R1 ts zero word", {20'd0, w}, word(0, 5));

    // R3 R5 R8 sweep over patterns
    for (int p = 0; p < 12; p++) begin
      logic [NR-1:0] m;
      int ts;
      m  = NR'((p * 32'h3A7B + 32'h1111) ^ (1 << p));
      if (m == '0) m = 16'h8001;
      ts = (p * 19 + 7) & 8'hFF;
      set_ts(TW'(ts));
      inject(m);
      for (int r = 0; r < NR; r++) begin
        if (m[r]) begin
          pop(w);
          chk("R3 R5 sweep word", {20'd0, w}, word(ts, r));
        end
      end
      tick(); tick();
      chk("R11 sweep empty", {31'd0, fifo_empty}, 32'd1);
      chk("R2 sweep flags drained", {16'd0, hit_flags}, 32'd0);
    end

    // R4 two cycles per pixel
    set_ts(8'h3C);
    inject(16'h00A4);
    chk("R4 E0", {16'd0, hit_flags}, 32'hA4);
    tick(); chk("R4 E1", {16'd0, hit_flags}, 32'hA4);
    tick(); chk("R4 E2", {16'd0, hit_flags}, 32'hA0);
    tick(); chk("R4 E3", {16'd0, hit_flags}, 32'hA0);
    tick(); chk("R4 E4", {16'd0, hit_flags}, 32'h80);
    tick(); chk("R4 E5", {16'd0, hit_flags}, 32'h80);
    tick(); chk("R4 E6", {16'd0, hit_flags}, 32'h00);
    pop(w); chk("R4 word a", {20'd0, w}, word(8'h3C, 2));
    pop(w); chk("R4 word b", {20'd0, w}, word(8'h3C, 5));
    pop(w); chk("R4 word c", {20'd0, w}, word(8'h3C, 7));

    // R8 R11 stall when full
    set_ts(8'hE1);
    inject(16'h003F);
    for (int k = 0; k < 20; k++) tick();
    chk("R11 full", {31'd0, fifo_full}, 32'd1);
    chk("R8 stalled flags", {16'd0, hit_flags}, 32'h30);
    for (int r = 0; r < 6; r++) begin
      pop(w);
      chk("R8 resume word", {20'd0, w}, word(8'hE1, r));
    end

    // R9 set wins over clear
    tick(); tick();
    inject(16'h0008);
    tick();
    hit_in = 16'h0008;
    tick();
    hit_in = '0;
    chk("R9 flag kept", {31'd0, hit_flags[3]}, 32'd1);
    pop(w); chk("R9 word 1", {20'd0, w}, word(8'hE1, 3));
    pop(w); chk("R9 word 2", {20'd0, w}, word(8'hE1, 3));

    // R6 held level does not recapture
    bx_ts = 8'h21; fast_or = 1'b1;
    tick(); tick();
    bx_ts = 8'h77;
    tick(); tick(); tick();
    inject(16'h0200);
    pop(w); chk("R6 held level", {20'd0, w}, word(8'h21, 9));
    fast_or = 1'b0; tick(); tick();
    bx_ts = 8'h44; fast_or = 1'b1; tick(); tick();
    inject(16'h0002);
    pop(w); chk("R6 new rise", {20'd0, w}, word(8'h44, 1));
    fast_or = 1'b0; tick(); tick();

    // R7 capture on the selection edge
    set_ts(8'h10);
    bx_ts = 8'h99;
    inject(16'h0040);
    fast_or = 1'b1;
    tick(); tick();
    fast_or = 1'b0;
    tick();
    inject(16'h0100);
    pop(w); chk("R7 old ts", {20'd0, w}, word(8'h10, 6));
    pop(w); chk("R7 new ts", {20'd0, w}, word(8'h99, 8));

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule